// File: doc/BRIEF.md
# Timer Channel Count-Source and Clear Control

This block is a single 16-bit timer channel counter. An 8-bit control word picks where count pulses come from, which transition of that source is counted, and which event resets the counter to zero. Count sources are the system clock itself, three slower rates taken from a free-running prescaler, or one of four external clock pins. Each pin is synchronized before its edges are detected.

Clear sources are compare/capture strobes from four general registers (A to D) and a clear request sent by peer channels that run in step with this one. Compare and capture detection happens outside this block, which only receives the resulting strobes. Flags for registers C and D mark those registers as buffers, and a buffer's strobe then never clears the counter. When this channel clears itself on one of its own register events and sync is enabled, it sends a one-cycle clear request to its peers. The counter wraps to zero after its top value and sets a sticky overflow flag. Any write to the control word clears that flag.

Top module: `tmr_chan_ctl`

## Requirements
- R1: While reset is held, the control word, counter, overflow flag and peer clear output all read 0.
- R2: A write strobe loads the write data into the control word, and the new value appears on the read port one cycle later. The field layout is: bits 7:5 clear select, bits 4:3 edge select, bits 2:0 source select.
- R3: Source code 000 advances the counter on every clock, whatever the edge select, so it counts 64 in any 64-cycle window.
- R4: Source codes 001, 010 and 011 use bits 1, 3 and 5 of a free-running 6-bit prescaler (divide by 4, 16, 64). Edge select 00 counts the 0-to-1 change of that bit, 01 counts the 1-to-0 change, and 10 or 11 count both. In any 64-cycle window this gives 16/16/32, 4/4/8 and 1/1/2 counts.
- R5: Source codes 100, 101, 110 and 111 count edges of `ext_clk_i` bits 0, 1, 2 and 3, using the same edge-select meaning as R4. A pin change made between clock edges shows on the counter after exactly three rising clock edges. Pins that are not selected have no effect.
- R6: Clear codes 001 and 010 clear the counter on a strobe on `gr_evt_i` bit 0 (A) and bit 1 (B) respectively. The counter reads 0 in the cycle after the strobe. A strobe on any other register does not clear it.
- R7: Clear codes 101 and 110 clear on `gr_evt_i` bit 2 (C) and bit 3 (D). The clear is suppressed when `buf_c_i` or `buf_d_i`, respectively, is set.
- R8: Clear codes 000 and 100 never clear the counter.
- R9: Clear codes 011 and 111 clear on `sync_clr_i`, but only while `sync_en_i` is 1.
- R10: A clear and a count in the same cycle leave the counter at 0.
- R11: A count at 0xFFFF gives 0 and sets the overflow flag. The flag stays set until a control write clears it. If a wrap and a write fall in the same cycle, the wrap wins and the flag is set.
- R12: `sync_clr_o` pulses for one cycle, in the cycle after this channel clears on its own register event (A to D) while `sync_en_i` is 1. It never pulses for a clear caused by a peer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_wr_i | input | 1 | Control word write strobe |
| ctl_wdata_i | input | 8 | Control word write data |
| ctl_q_o | output | 8 | Current control word |
| ext_clk_i | input | 4 | External clock pins A..D (bit 0..3) |
| gr_evt_i | input | 4 | Compare/capture strobes for registers A..D |
| buf_c_i | input | 1 | Register C is used as a buffer |
| buf_d_i | input | 1 | Register D is used as a buffer |
| sync_clr_i | input | 1 | Clear request from peer channels |
| sync_en_i | input | 1 | Channel takes part in synchronous operation |
| cnt_o | output | 16 | Counter value |
| ovf_o | output | 1 | Sticky overflow flag |
| sync_clr_o | output | 1 | Clear request to peer channels |

## Verification
The control word, counter clears and the peer clear pulse each settle one rising edge after their cause. A pin change settles three rising edges later: two synchronizer stages, then one edge-history stage. The bench drives every input just after a falling edge and samples at a later falling edge. It samples one falling edge after a strobe, or three after a pin change, and checks one edge earlier that the pin result has not yet appeared. Prescaled rates do not depend on prescaler phase, so they are measured as the count difference over exactly 64 falling edges.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int CNT_W    = 16;
    localparam int NUM_PINS = 4;
    localparam int NUM_DIV  = 3;

    typedef struct packed {
        logic [2:0] clr_sel;
        logic [1:0] edge_sel;
        logic [2:0] src_sel;
    } ctl_t;

    typedef enum logic [1:0] {
        EDGE_RISE  = 2'b00,
        EDGE_FALL  = 2'b01,
        EDGE_BOTHA = 2'b10,
        EDGE_BOTHB = 2'b11
    } edge_e;

    function automatic logic edge_hit(input logic [1:0] sel, input logic rise, input logic fall);
        logic hit;
        unique case (edge_e'(sel))
            EDGE_RISE:  hit = rise;
            EDGE_FALL:  hit = fall;
            default:    hit = rise | fall;
        endcase
        return hit;
    endfunction

endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
    parameter int NUM_DIV = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    output logic [NUM_DIV-1:0] rise_o,
    output logic [NUM_DIV-1:0] fall_o
);
    localparam int PRE_W = 2 * NUM_DIV;

    logic [PRE_W-1:0] pre_q;

    always_ff @(posedge clk) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_q + 1'b1;
    end

    // Tap i is bit 2*i+1: a square wave of period 4^(i+1).
    // The pulses mark the cycle in which that bit is about to change.
    for (genvar i = 0; i < NUM_DIV; i++) begin : g_tap
        localparam int B = 2 * i + 1;
        assign rise_o[i] = (&pre_q[B-1:0]) & ~pre_q[B];
        assign fall_o[i] = (&pre_q[B-1:0]) &  pre_q[B];
    end

endmodule

// File: rtl/tmr_pin_edge.sv
module tmr_pin_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic rise_o,
    output logic fall_o
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], pin_i};
            prev_q <= sync_q[SYNC_STAGES-1];
        end
    end

    assign rise_o =  sync_q[SYNC_STAGES-1] & ~prev_q;
    assign fall_o = ~sync_q[SYNC_STAGES-1] &  prev_q;

endmodule

// File: rtl/tmr_clr_sel.sv
module tmr_clr_sel (
    input  logic [2:0] clr_sel_i,
    input  logic [3:0] evt_i,
    input  logic       buf_c_i,
    input  logic       buf_d_i,
    input  logic       sync_clr_i,
    input  logic       sync_en_i,
    output logic       clr_o,
    output logic       own_clr_o
);
    always_comb begin
        own_clr_o = 1'b0;
        clr_o     = 1'b0;
        unique case (clr_sel_i)
            3'b001: own_clr_o = evt_i[0];
            3'b010: own_clr_o = evt_i[1];
            3'b101: own_clr_o = evt_i[2] & ~buf_c_i;
            3'b110: own_clr_o = evt_i[3] & ~buf_d_i;
            3'b011,
            3'b111: clr_o     = sync_clr_i & sync_en_i;
            default: begin
                own_clr_o = 1'b0;
                clr_o     = 1'b0;
            end
        endcase
        clr_o = clr_o | own_clr_o;
    end

endmodule

// File: rtl/tmr_chan_ctl.sv
module tmr_chan_ctl
    import tmr_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ctl_wr_i,
    input  logic [7:0]          ctl_wdata_i,
    output logic [7:0]          ctl_q_o,
    input  logic [NUM_PINS-1:0] ext_clk_i,
    input  logic [3:0]          gr_evt_i,
    input  logic                buf_c_i,
    input  logic                buf_d_i,
    input  logic                sync_clr_i,
    input  logic                sync_en_i,
    output logic [CNT_W-1:0]    cnt_o,
    output logic                ovf_o,
    output logic                sync_clr_o
);
    ctl_t               ctl_q;
    logic [CNT_W-1:0]   cnt_q;
    logic               ovf_q;
    logic               sclr_q;
    logic [NUM_DIV-1:0] div_rise, div_fall;
    logic [NUM_PINS-1:0] pin_rise, pin_fall;
    logic               tick, clr, own_clr;

    tmr_prescale #(.NUM_DIV(NUM_DIV)) u_pre (
        .clk    (clk),
        .rst_n  (rst_n),
        .rise_o (div_rise),
        .fall_o (div_fall)
    );

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        tmr_pin_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
            .clk    (clk),
            .rst_n  (rst_n),
            .pin_i  (ext_clk_i[p]),
            .rise_o (pin_rise[p]),
            .fall_o (pin_fall[p])
        );
    end

    tmr_clr_sel u_clr (
        .clr_sel_i  (ctl_q.clr_sel),
        .evt_i      (gr_evt_i),
        .buf_c_i    (buf_c_i),
        .buf_d_i    (buf_d_i),
        .sync_clr_i (sync_clr_i),
        .sync_en_i  (sync_en_i),
        .clr_o      (clr),
        .own_clr_o  (own_clr)
    );

    // Count source: undivided clock ignores the edge select.
    always_comb begin
        if (ctl_q.src_sel[2]) begin
            tick = edge_hit(ctl_q.edge_sel, pin_rise[ctl_q.src_sel[1:0]],
                            pin_fall[ctl_q.src_sel[1:0]]);
        end else if (ctl_q.src_sel[1:0] == 2'd0) begin
            tick = 1'b1;
        end else begin
            tick = edge_hit(ctl_q.edge_sel, div_rise[ctl_q.src_sel[1:0] - 2'd1],
                            div_fall[ctl_q.src_sel[1:0] - 2'd1]);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q  <= '0;
            cnt_q  <= '0;
            ovf_q  <= 1'b0;
            sclr_q <= 1'b0;
        end else begin
            if (ctl_wr_i) ctl_q <= ctl_t'(ctl_wdata_i);
            if (clr)       cnt_q <= '0;
            else if (tick) cnt_q <= cnt_q + 1'b1;
            if (tick && !clr && (&cnt_q)) ovf_q <= 1'b1;
            else if (ctl_wr_i)            ovf_q <= 1'b0;
            sclr_q <= own_clr & sync_en_i;
        end
    end

    assign ctl_q_o    = ctl_q;
    assign cnt_o      = cnt_q;
    assign ovf_o      = ovf_q;
    assign sync_clr_o = sclr_q;

endmodule

// File: rtl/tmr_chan_ctl_chk.sv
module tmr_chan_ctl_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        ctl_wr_i,
    input logic [7:0]  ctl_q_o,
    input logic [3:0]  gr_evt_i,
    input logic        buf_c_i,
    input logic        sync_en_i,
    input logic [15:0] cnt_o,
    input logic        ovf_o,
    input logic        sync_clr_o
);
    // R3
    div1_free_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q_o[7:5] == 3'b000 && ctl_q_o[2:0] == 3'b000) |=> cnt_o == $past(cnt_o) + 16'd1);

    // R6
    clear_on_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q_o[7:5] == 3'b001 && gr_evt_i[0]) |=> cnt_o == 16'd0);

    // R7
    buffer_blocks_c_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q_o[7:5] == 3'b101 && buf_c_i) |=> !sync_clr_o);

    // R11
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_o && !ctl_wr_i) |=> ovf_o);

    // R11
    ovf_rise_at_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf_o) |-> $past(cnt_o) == 16'hFFFF);

    // R12
    sync_out_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sync_clr_o |-> $past(sync_en_i));

    // R12
    no_echo_of_peer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q_o[6:5] == 2'b11) |=> !sync_clr_o);

endmodule

bind tmr_chan_ctl tmr_chan_ctl_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctl_wr_i   (ctl_wr_i),
    .ctl_q_o    (ctl_q_o),
    .gr_evt_i   (gr_evt_i),
    .buf_c_i    (buf_c_i),
    .sync_en_i  (sync_en_i),
    .cnt_o      (cnt_o),
    .ovf_o      (ovf_o),
    .sync_clr_o (sync_clr_o)
);

// File: tb/tmr_chan_ctl_tb.sv
`timescale 1ns/1ps
module tmr_chan_ctl_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctl_wr_i = 1'b0;
    logic [7:0]  ctl_wdata_i = '0;
    logic [7:0]  ctl_q_o;
    logic [3:0]  ext_clk_i = '0;
    logic [3:0]  gr_evt_i = '0;
    logic        buf_c_i = 1'b0;
    logic        buf_d_i = 1'b0;
    logic        sync_clr_i = 1'b0;
    logic        sync_en_i = 1'b0;
    logic [15:0] cnt_o;
    logic        ovf_o;
    logic        sync_clr_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    tmr_chan_ctl u_dut (
        .clk(clk), .rst_n(rst_n), .ctl_wr_i(ctl_wr_i), .ctl_wdata_i(ctl_wdata_i),
        .ctl_q_o(ctl_q_o), .ext_clk_i(ext_clk_i), .gr_evt_i(gr_evt_i),
        .buf_c_i(buf_c_i), .buf_d_i(buf_d_i), .sync_clr_i(sync_clr_i),
        .sync_en_i(sync_en_i), .cnt_o(cnt_o), .ovf_o(ovf_o), .sync_clr_o(sync_clr_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr_ctl(input logic [7:0] v);
        ctl_wr_i = 1'b1;
        ctl_wdata_i = v;
        @(negedge clk);
        ctl_wr_i = 1'b0;
    endtask

    task automatic t_reset;
        repeat (3) @(negedge clk);
        chk("R1 ctl", ctl_q_o, 0);
        chk("R1 cnt", cnt_o, 0);
        chk("R1 ovf", ovf_o, 0);
        chk("R1 sync_clr_o", sync_clr_o, 0);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_ctl_write;
        wr_ctl(8'hA5);
        chk("R2 readback", ctl_q_o, 8'hA5);
        wr_ctl(8'h00);
        chk("R2 readback zero", ctl_q_o, 8'h00);
    endtask

    task automatic rate(input string req, input logic [7:0] v, input int exp);
        logic [15:0] c0;
        wr_ctl(v);
        c0 = cnt_o;
        repeat (64) @(negedge clk);
        chk(req, 32'(cnt_o - c0), exp);
    endtask

    task automatic t_rates;
        rate("R3 div1 rise",      8'b000_00_000, 64);
        rate("R3 div1 both",      8'b000_10_000, 64);
        rate("R4 div4 rise",      8'b000_00_001, 16);
        rate("R4 div4 fall",      8'b000_01_001, 16);
        rate("R4 div4 both",      8'b000_10_001, 32);
        rate("R4 div16 rise",     8'b000_00_010, 4);
        rate("R4 div16 both",     8'b000_11_010, 8);
        rate("R4 div64 fall",     8'b000_01_011, 1);
        rate("R4 div64 both",     8'b000_10_011, 2);
    endtask

    task automatic t_pins;
        logic [15:0] c0;
        // pin C, both edges; pin A toggled too and must be ignored
        wr_ctl(8'b000_10_110);
        c0 = cnt_o;
        ext_clk_i[2] = 1'b1; ext_clk_i[0] = 1'b1;
        repeat (6) @(negedge clk);
        ext_clk_i[2] = 1'b0; ext_clk_i[0] = 1'b0;
        repeat (6) @(negedge clk);
        chk("R5 pin C both edges", 32'(cnt_o - c0), 2);
        // pin A, rising only
        wr_ctl(8'b000_00_100);
        c0 = cnt_o;
        ext_clk_i[0] = 1'b1;
        repeat (6) @(negedge clk);
        ext_clk_i[0] = 1'b0;
        repeat (6) @(negedge clk);
        chk("R5 pin A rising", 32'(cnt_o - c0), 1);
        // pin D, falling only
        wr_ctl(8'b000_01_111);
        c0 = cnt_o;
        ext_clk_i[3] = 1'b1;
        repeat (6) @(negedge clk);
        chk("R5 pin D rise ignored", 32'(cnt_o - c0), 0);
        ext_clk_i[3] = 1'b0;
        repeat (6) @(negedge clk);
        chk("R5 pin D falling", 32'(cnt_o - c0), 1);
        // pin B latency: three rising edges
        wr_ctl(8'b000_00_101);
        c0 = cnt_o;
        ext_clk_i[1] = 1'b1;
        repeat (2) @(negedge clk);
        chk("R5 pin B not yet", 32'(cnt_o - c0), 0);
        @(negedge clk);
        chk("R5 pin B after 3 edges", 32'(cnt_o - c0), 1);
        ext_clk_i[1] = 1'b0;
        repeat (6) @(negedge clk);
    endtask

    task automatic clr_case(input string req, input logic [2:0] sel, input logic [3:0] evt,
                            input logic bc, input logic bd, input logic sclr, input logic sen,
                            input logic exp_clr, input logic exp_out);
        logic [15:0] c0;
        wr_ctl({sel, 5'b00_000});
        sync_en_i = sen; buf_c_i = bc; buf_d_i = bd;
        repeat (2) @(negedge clk);
        c0 = cnt_o;
        gr_evt_i = evt; sync_clr_i = sclr;
        @(negedge clk);
        gr_evt_i = '0; sync_clr_i = 1'b0;
        chk({req, " cnt"}, cnt_o, exp_clr ? 32'd0 : 32'(c0 + 16'd1));
        chk({req, " sync_clr_o"}, sync_clr_o, exp_out);
        @(negedge clk);
        chk({req, " sync_clr_o drops"}, sync_clr_o, 0);
        sync_en_i = 1'b0; buf_c_i = 1'b0; buf_d_i = 1'b0;
    endtask

    task automatic t_clears;
        clr_case("R6 A clears (R10)",       3'b001, 4'b0001, 0, 0, 0, 0, 1, 0);
        clr_case("R6 B other reg ignored",  3'b001, 4'b0010, 0, 0, 0, 1, 0, 0);
        clr_case("R6 B clears R12 pulse",   3'b010, 4'b0010, 0, 0, 0, 1, 1, 1);
        clr_case("R8 code 000 no clear",    3'b000, 4'b1111, 0, 0, 1, 1, 0, 0);
        clr_case("R8 code 100 no clear",    3'b100, 4'b1111, 0, 0, 1, 1, 0, 0);
        clr_case("R7 C buffered",           3'b101, 4'b0100, 1, 0, 0, 1, 0, 0);
        clr_case("R7 C clears",             3'b101, 4'b0100, 0, 0, 0, 0, 1, 0);
        clr_case("R7 D buffered",           3'b110, 4'b1000, 0, 1, 0, 1, 0, 0);
        clr_case("R7 D clears R12 pulse",   3'b110, 4'b1000, 0, 0, 0, 1, 1, 1);
        clr_case("R9 peer no sync enable",  3'b011, 4'b0000, 0, 0, 1, 0, 0, 0);
        clr_case("R9 peer clears R12 none", 3'b011, 4'b0000, 0, 0, 1, 1, 1, 0);
        clr_case("R9 code 111 peer clears", 3'b111, 4'b0000, 0, 0, 1, 1, 1, 0);
    endtask

    task automatic t_overflow;
        int guard = 0;
        wr_ctl(8'h00);
        chk("R11 ovf clear before wrap", ovf_o, 0);
        while (cnt_o != 16'hFFFF && guard < 70000) begin
            @(negedge clk);
            guard++;
        end
        @(negedge clk);
        chk("R11 wrap to zero", cnt_o, 0);
        chk("R11 ovf set", ovf_o, 1);
        repeat (3) @(negedge clk);
        chk("R11 ovf sticky", ovf_o, 1);
        wr_ctl(8'h00);
        chk("R11 write clears ovf", ovf_o, 0);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_ctl_write();
        t_rates();
        t_pins();
        t_clears();
        t_overflow();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog R1-all actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule